// File: doc/BRIEF.md
# Serial Card Block Writer

This engine sends one fixed-length data block to a memory card over a single bidirectional data line. It then stays on that line for the card's reply. After a start strobe it pulls payload bytes from a valid/ready stream. It drives a low start bit, the payload bits MSB first, a 16-bit CRC of the payload and a high end bit, one bit per clock.

After a short turnaround with the line released, the engine looks for the card's status token. It decodes whether the block was taken or refused for a CRC mismatch. It then waits while the card holds the line low during programming. A one-cycle done pulse ends the transfer, and the accepted, CRC-error and timeout flags are valid from that pulse onward.

The block length is a parameter and must match the length already agreed with the card. Command signalling and clock generation are left to neighbouring logic.

Top module: `dat_blk_writer`

## Requirements
- R1: The line is released (dat_oe_o low) while idle. When start_i is sampled with a byte already offered, the engine drives a 0 start bit two clocks later, then the payload bits MSB first, then the CRC, then a 1 end bit, one bit per clock, and then releases the line.
- R2: Exactly BLK_BYTES bytes are taken per block, through data_ready_o and data_valid_i, with one byte of lookahead. data_ready_o is low while idle. The source must refill the lookahead within 8 clocks.
- R3: The 16-bit CRC uses generator 0x1021 with an all-zero start value. It is computed over the payload bits only and sent MSB first right after the last payload bit.
- R4: After the end bit the line stays released for TURN_CYC clocks. The engine then samples dat_i for a 0 status start bit for at most STAT_WAIT clocks. If no 0 is seen, the transfer ends with timeout_o set and both accepted_o and crc_err_o low.
- R5: The 8 bits after the status start bit form the status byte, MSB first. Low three bits equal to 010 set accepted_o. Any other value sets crc_err_o. The upper five bits do not matter, and the bit after the status byte is not checked.
- R6: From the second clock after the last status bit, every low sample of dat_i counts as busy. The transfer ends on the first high sample.
- R7: If more than busy_limit_i busy samples occur, the transfer ends with timeout_o set. accepted_o and crc_err_o still report the decoded status.
- R8: done_o is a single-cycle pulse. All three flags clear when a start is taken, and they hold their final values from the done pulse until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one line bit per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin one block transfer (taken while idle) |
| busy_limit_i | input | BUSY_W | Maximum busy samples tolerated |
| data_i | input | 8 | Payload byte |
| data_valid_i | input | 1 | Payload byte offered |
| data_ready_o | output | 1 | Payload byte taken when valid |
| dat_oe_o | output | 1 | Data line output enable |
| dat_o | output | 1 | Data line output value |
| dat_i | input | 1 | Data line input value |
| done_o | output | 1 | Transfer finished (one-cycle pulse) |
| accepted_o | output | 1 | Card accepted the block |
| crc_err_o | output | 1 | Card reported a CRC mismatch |
| timeout_o | output | 1 | Missing status start bit or busy too long |

## Verification
The bench builds the engine with BLK_BYTES=4, STAT_WAIT=16, TURN_CYC=2 and BUSY_W=8, and programs busy_limit_i to 6 or 20. The short block keeps every transfer near a hundred cycles, so each status-search boundary can be run in turn. These are a start bit on the last allowed sample (15 high samples first) and a missed start bit (16 high samples). The small limit puts the busy boundary in reach: exactly six low samples finish cleanly, while seven raise the timeout.

// File: rtl/dbw_pkg.sv
package dbw_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_SOF, S_DATA, S_CRC, S_EOF,
    S_TURN, S_WSTAT, S_STAT, S_SEND, S_BUSY
  } dbw_state_e;

  localparam logic [15:0] CRC16_POLY = 16'h1021;
  localparam logic [2:0]  STAT_OK    = 3'b010;
endpackage

// File: rtl/dbw_crc16.sv
module dbw_crc16 #(
  parameter logic [15:0] POLY = dbw_pkg::CRC16_POLY
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic upd_i,
  input  logic bit_i,
  input  logic shift_i,
  output logic msb_o
);
  logic [15:0] crc_q;
  logic        fb;

  assign fb    = crc_q[15] ^ bit_i;
  assign msb_o = crc_q[15];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       crc_q <= '0;
    else if (clr_i)    crc_q <= '0;
    else if (upd_i)    crc_q <= {crc_q[14:0], 1'b0} ^ (fb ? POLY : 16'h0000);
    else if (shift_i)  crc_q <= {crc_q[14:0], 1'b0};
  end
endmodule

// File: rtl/dbw_byte_feed.sv
module dbw_byte_feed #(
  parameter int BLK_BYTES = 512
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic [7:0] data_i,
  input  logic       valid_i,
  input  logic       load_i,
  input  logic       shift_i,
  output logic       ready_o,
  output logic       full_o,
  output logic       msb_o
);
  localparam int CW = $clog2(BLK_BYTES + 1);
  localparam logic [CW-1:0] NBYTES = CW'(BLK_BYTES);

  logic [7:0]    buf_q, sh_q;
  logic          full_q, take;
  logic [CW-1:0] fetched_q;

  assign ready_o = en_i && !full_q && (fetched_q < NBYTES);
  assign take    = ready_o && valid_i;
  assign full_o  = full_q;
  assign msb_o   = sh_q[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q     <= '0;
      sh_q      <= '0;
      full_q    <= 1'b0;
      fetched_q <= '0;
    end else if (clr_i) begin
      full_q    <= 1'b0;
      fetched_q <= '0;
    end else begin
      if (take) begin
        buf_q     <= data_i;
        fetched_q <= fetched_q + 1'b1;
      end
      full_q <= take | (full_q & ~load_i);
      if (load_i)       sh_q <= buf_q;
      else if (shift_i) sh_q <= {sh_q[6:0], 1'b0};
    end
  end

  // lookahead must hold a byte whenever the shifter reloads
  assert_load_has_byte_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> full_q);
endmodule

// File: rtl/dbw_reply_rx.sv
module dbw_reply_rx (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       shift_i,
  input  logic       bit_i,
  output logic [7:0] status_o,
  output logic       ok_o
);
  logic [7:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      st_q <= '0;
    else if (clr_i)   st_q <= '0;
    else if (shift_i) st_q <= {st_q[6:0], bit_i};
  end

  assign status_o = st_q;
  assign ok_o     = (st_q[2:0] == dbw_pkg::STAT_OK);
endmodule

// File: rtl/dat_blk_writer.sv
module dat_blk_writer #(
  parameter int BLK_BYTES = 512,
  parameter int STAT_WAIT = 16,
  parameter int TURN_CYC  = 2,
  parameter int BUSY_W    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BUSY_W-1:0] busy_limit_i,
  input  logic [7:0]        data_i,
  input  logic              data_valid_i,
  output logic              data_ready_o,
  output logic              dat_oe_o,
  output logic              dat_o,
  input  logic              dat_i,
  output logic              done_o,
  output logic              accepted_o,
  output logic              crc_err_o,
  output logic              timeout_o
);
  import dbw_pkg::*;

  localparam int BYTE_W = (BLK_BYTES > 1) ? $clog2(BLK_BYTES) : 1;
  localparam int CNT_W  = (BUSY_W > 6) ? BUSY_W : 6;
  localparam logic [BYTE_W-1:0] LAST_BYTE = BYTE_W'(BLK_BYTES - 1);
  localparam logic [CNT_W-1:0]  CRC_LAST  = CNT_W'(15);
  localparam logic [CNT_W-1:0]  TURN_LAST = CNT_W'(TURN_CYC - 1);
  localparam logic [CNT_W-1:0]  WAIT_LAST = CNT_W'(STAT_WAIT - 1);
  localparam logic [CNT_W-1:0]  STAT_LAST = CNT_W'(7);

  dbw_state_e        state_q;
  logic [2:0]        bit_q;
  logic [BYTE_W-1:0] byte_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              done_q, acc_q, cerr_q, tmo_q;

  logic begin_xfer;
  logic feed_en, feed_load, feed_shift, feed_full, feed_msb;
  logic crc_upd, crc_shift, crc_msb;
  logic rx_shift, rx_ok;
  logic [7:0] rx_status;

  assign begin_xfer = (state_q == S_IDLE) && start_i;

  dbw_byte_feed #(.BLK_BYTES(BLK_BYTES)) u_feed (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(begin_xfer), .en_i(feed_en),
    .data_i(data_i), .valid_i(data_valid_i), .load_i(feed_load),
    .shift_i(feed_shift), .ready_o(data_ready_o), .full_o(feed_full),
    .msb_o(feed_msb)
  );

  dbw_crc16 u_crc (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(begin_xfer), .upd_i(crc_upd),
    .bit_i(feed_msb), .shift_i(crc_shift), .msb_o(crc_msb)
  );

  dbw_reply_rx u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(begin_xfer), .shift_i(rx_shift),
    .bit_i(dat_i), .status_o(rx_status), .ok_o(rx_ok)
  );

  always_comb begin
    dat_oe_o   = 1'b0;
    dat_o      = 1'b1;
    feed_en    = 1'b0;
    feed_load  = 1'b0;
    feed_shift = 1'b0;
    crc_upd    = 1'b0;
    crc_shift  = 1'b0;
    rx_shift   = 1'b0;
    unique case (state_q)
      S_FETCH: begin
        feed_en   = 1'b1;
        feed_load = feed_full;
      end
      S_SOF: begin
        dat_oe_o = 1'b1;
        dat_o    = 1'b0;
        feed_en  = 1'b1;
      end
      S_DATA: begin
        dat_oe_o = 1'b1;
        dat_o    = feed_msb;
        feed_en  = 1'b1;
        crc_upd  = 1'b1;
        if (bit_q == 3'd7) feed_load  = (byte_q != LAST_BYTE);
        else               feed_shift = 1'b1;
      end
      S_CRC: begin
        dat_oe_o  = 1'b1;
        dat_o     = crc_msb;
        crc_shift = 1'b1;
      end
      S_EOF: begin
        dat_oe_o = 1'b1;
        dat_o    = 1'b1;
      end
      S_STAT:  rx_shift = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      bit_q   <= '0;
      byte_q  <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      acc_q   <= 1'b0;
      cerr_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          state_q <= S_FETCH;
          acc_q   <= 1'b0;
          cerr_q  <= 1'b0;
          tmo_q   <= 1'b0;
        end
        S_FETCH: if (feed_full) state_q <= S_SOF;
        S_SOF: begin
          state_q <= S_DATA;
          bit_q   <= '0;
          byte_q  <= '0;
        end
        S_DATA: begin
          bit_q <= bit_q + 3'd1;
          if (bit_q == 3'd7) begin
            if (byte_q == LAST_BYTE) begin
              state_q <= S_CRC;
              cnt_q   <= '0;
            end else begin
              byte_q <= byte_q + 1'b1;
            end
          end
        end
        S_CRC: begin
          if (cnt_q == CRC_LAST) state_q <= S_EOF;
          else                   cnt_q   <= cnt_q + 1'b1;
        end
        S_EOF: begin
          state_q <= S_TURN;
          cnt_q   <= '0;
        end
        S_TURN: begin
          if (cnt_q == TURN_LAST) begin
            state_q <= S_WSTAT;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_WSTAT: begin
          if (!dat_i) begin
            state_q <= S_STAT;
            cnt_q   <= '0;
          end else if (cnt_q == WAIT_LAST) begin
            state_q <= S_IDLE;
            done_q  <= 1'b1;
            tmo_q   <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_STAT: begin
          if (cnt_q == STAT_LAST) state_q <= S_SEND;
          else                    cnt_q   <= cnt_q + 1'b1;
        end
        S_SEND: begin
          state_q <= S_BUSY;
          cnt_q   <= '0;
        end
        S_BUSY: begin
          if (dat_i || cnt_q == CNT_W'(busy_limit_i)) begin
            state_q <= S_IDLE;
            done_q  <= 1'b1;
            acc_q   <= rx_ok;
            cerr_q  <= ~rx_ok;
            tmo_q   <= ~dat_i;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign done_o     = done_q;
  assign accepted_o = acc_q;
  assign crc_err_o  = cerr_q;
  assign timeout_o  = tmo_q;

  assert_sof_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dat_oe_o) |-> !dat_o);
  assert_eof_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dat_oe_o) |-> $past(dat_o));
  assert_flags_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(accepted_o && crc_err_o));
  assert_tmo_at_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> done_o);
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_status_unused_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !timeout_o |-> (accepted_o == (rx_status[2:0] == STAT_OK)));
endmodule

// File: tb/dat_blk_writer_tb.sv
module dat_blk_writer_tb;
  localparam int NB = 4;
  localparam int SW = 16;
  localparam int TC = 2;
  localparam int BW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [BW-1:0] blim = '0;
  logic [7:0] data;
  logic valid;
  logic ready, oe, dout, din, done, acc, cerr, tmo;

  logic [7:0] pay [NB];
  int idx = 0;
  int nvec = 0;
  int nerr = 0;

  always #2.5 clk = ~clk;

  assign data  = (idx < NB) ? pay[idx] : 8'h00;
  assign valid = (idx < NB);

  dat_blk_writer #(.BLK_BYTES(NB), .STAT_WAIT(SW), .TURN_CYC(TC), .BUSY_W(BW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .busy_limit_i(blim),
    .data_i(data), .data_valid_i(valid), .data_ready_o(ready),
    .dat_oe_o(oe), .dat_o(dout), .dat_i(din), .done_o(done),
    .accepted_o(acc), .crc_err_o(cerr), .timeout_o(tmo)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc();
    logic [15:0] c = 16'h0000;
    for (int b = 0; b < NB; b++)
      for (int i = 7; i >= 0; i--) begin
        logic fb = c[15] ^ pay[b][i];
        c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
      end
    return c;
  endfunction

  // card reply for the sample taken at relative posedge s
  function automatic logic card_bit(int s, int w, int g, logic [7:0] st, int b);
    if (s <= w + g)      return 1'b1;
    if (s == w + g + 1)  return 1'b0;
    if (s <= w + g + 9)  return st[7 - (s - (w + g + 2))];
    if (s == w + g + 10) return 1'b1;
    if (s <= w + g + 10 + b) return 1'b0;
    return 1'b1;
  endfunction

  task automatic run_block(input logic [31:0] p, input int g, input logic [7:0] st,
                           input int b, input int lim);
    logic [15:0] crc;
    int w, done_k;
    logic e_acc, e_cerr, e_tmo;
    string dtag;
    bit take_prev = 1'b0;
    for (int i = 0; i < NB; i++) pay[i] = p[31 - 8*i -: 8];
    crc = ref_crc();
    w = 20 + 8*NB + TC;
    if (g >= SW) begin
      done_k = w + SW; e_acc = 0; e_cerr = 0; e_tmo = 1; dtag = "R4";
    end else begin
      e_acc  = (st[2:0] == 3'b010);
      e_cerr = !e_acc;
      if (b > lim) begin
        done_k = w + g + 11 + lim; e_tmo = 1; dtag = "R7";
      end else begin
        done_k = w + g + 11 + b; e_tmo = 0; dtag = "R6";
      end
    end
    blim = BW'(lim);
    @(negedge clk);
    idx = 0;
    start = 1'b1;
    din = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k <= done_k + 2; k++) begin
      logic e_oe, e_o;
      string ltag;
      if (k > 0) @(negedge clk);
      if (take_prev) idx++;
      e_oe = 1'b0; e_o = 1'b1; ltag = "R1";
      if (k == 2) begin
        e_oe = 1; e_o = 0;
      end else if (k >= 3 && k < 3 + 8*NB) begin
        e_oe = 1; e_o = pay[(k-3)/8][7 - (k-3)%8];
      end else if (k >= 3 + 8*NB && k < 19 + 8*NB) begin
        e_oe = 1; e_o = crc[15 - (k - 3 - 8*NB)]; ltag = "R3";
      end else if (k == 19 + 8*NB) begin
        e_oe = 1; e_o = 1;
      end else if (k > 19 + 8*NB) begin
        ltag = "R4";
      end
      chk(oe == e_oe, ltag, int'(oe), int'(e_oe));
      if (e_oe) chk(dout == e_o, ltag, int'(dout), int'(e_o));
      chk(done == (k == done_k), (k == done_k) ? dtag : "R8", int'(done), int'(k == done_k));
      if (k >= done_k)
        chk({acc, cerr, tmo} == {e_acc, e_cerr, e_tmo}, "R5", int'({acc, cerr, tmo}),
            int'({e_acc, e_cerr, e_tmo}));
      else
        chk({acc, cerr, tmo} == 3'b000, "R8", int'({acc, cerr, tmo}), 0);
      take_prev = ready && valid;
      din = card_bit(k + 1, w, g, st, b);
    end
    chk(idx == NB, "R2", idx, NB);
    chk(ready == 1'b0, "R2", int'(ready), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    din = 1'b1;
    for (int i = 0; i < NB; i++) pay[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(oe == 1'b0, "R1", int'(oe), 0);
    chk(done == 1'b0, "R8", int'(done), 0);
    chk({acc, cerr, tmo} == 3'b000, "R8", int'({acc, cerr, tmo}), 0);
    chk(ready == 1'b0, "R2", int'(ready), 0);
    run_block(32'hA53C00FF, 0,  8'hFA, 5, 20);  // accepted, R5 R6
    run_block(32'h12345678, 3,  8'h0D, 0, 20);  // crc error, no busy
    run_block(32'h00000000, 15, 8'h0A, 2, 20);  // last allowed start sample, R4
    run_block(32'hFFFFFFFF, 16, 8'hFA, 0, 20);  // status start missed, R4
    run_block(32'h5AC3961E, 1,  8'h02, 6, 6);   // busy exactly at limit, R7
    run_block(32'h0F1E2D3C, 1,  8'h02, 7, 6);   // busy one past limit, R7
    run_block(32'h80010203, 0,  8'hFF, 3, 20);  // low bits 111 rejected, R5
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule